// File: doc/BRIEF.md
# Transmit Pacing Interval Timer

This block paces successive transmissions from a message queue. It marks the end of a programmable wait interval with a one-cycle `done_pulse`. The wait is measured in ticks from one of three count sources: the system clock divided by a 16-bit prescale value, that divided clock slowed by a further fixed factor of ten, or an external bit-time tick supplied by the protocol engine. A two-bit code picks the source. An 8-bit interval value sets how many source ticks make up one interval.

Counting runs only while `cnt_en` is high. Dropping `cnt_en` returns every internal counter to zero. Each interval restarts on its own after the pulse for as long as `cnt_en` stays high. The block takes its configuration inputs only while `cnt_en` is low, so a running interval cannot be disturbed by changes to its settings.

Top module: `interval_pacer`

## Requirements
- R1: During reset and after reset with `cnt_en` low, `done_pulse` is 0.
- R2: With `src_sel` = 00, `prescale_m` = M ≥ 1 and `interval_n` = N ≥ 1, `done_pulse` is high in enabled cycle k (the first cycle with `cnt_en` high is k = 1) exactly when k is a multiple of M·N.
- R3: With `src_sel` = 10, `done_pulse` is high in enabled cycle k exactly when k is a multiple of M·10·N.
- R4: With `src_sel` = 01 or 11, `done_pulse` is high in the same cycle as every N-th pulse of `bit_tick` seen while enabled, and never in a cycle without a `bit_tick` pulse. The upper select bit has no effect.
- R5: With `interval_n` = 0, `done_pulse` is high in every cycle that `cnt_en` is high, including the first one.
- R6: A `prescale_m` of 0 gives the same timing as a `prescale_m` of 1.
- R7: After each pulse the interval restarts on its own, so the pulses repeat with a fixed period for as long as `cnt_en` stays high.
- R8: While `cnt_en` is low, `done_pulse` is 0. After `cnt_en` rises again, counting starts from zero, with no progress kept from before.
- R9: Changes to `prescale_m`, `interval_n` or `src_sel` while `cnt_en` is high have no effect until `cnt_en` has been low for at least one clock edge.
- R10: `bit_tick` has no effect when `src_sel` is 00 or 10, or when `cnt_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Count enable; low clears all counters and opens the configuration |
| bit_tick | input | 1 | One-cycle bit-time pulse, synchronous to `clk` |
| prescale_m | input | 16 | System clock divide value M (0 acts as 1) |
| src_sel | input | 2 | Count source: 00 prescaled, 10 prescaled ÷10, x1 bit tick |
| interval_n | input | 8 | Interval length N in source ticks (0 to 255) |
| done_pulse | output | 1 | High for one cycle when an interval ends |

## Verification
`done_pulse` is decoded without a register from the counter state and from the present `cnt_en` and `bit_tick`. It therefore rises in the same cycle as the enabled clock or bit tick that completes the interval, in the M·N-th (or M·10·N-th) enabled cycle or on the N-th tick. A configuration driven while `cnt_en` is low takes effect at the next clock edge. The bench drives all inputs just after the falling edge and compares `done_pulse` a moment later in every enabled cycle against a cycle counter and tick counter of its own. It uses the settings that were frozen when `cnt_en` rose, and it confirms that the output stays quiet in the first cycle after `cnt_en` falls.

// File: rtl/pacer_pkg.sv
package pacer_pkg;

   typedef enum logic [1:0] {
      SRC_BASE   = 2'd0,
      SRC_DECADE = 2'd1,
      SRC_EXT    = 2'd2
   } pacer_src_e;

   // Low select bit set picks the external tick; the upper bit then does not matter.
   function automatic pacer_src_e decode_src(input logic [1:0] sel);
      if (sel[0])
         return SRC_EXT;
      else if (sel[1])
         return SRC_DECADE;
      else
         return SRC_BASE;
   endfunction

endpackage

// File: rtl/pacer_modcnt.sv
module pacer_modcnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         adv,
   input  logic [W-1:0] limit,
   output logic [W-1:0] cnt,
   output logic         wrap
);

   generate
      if (W < 1) begin : g_bad_width
         initial $error("pacer_modcnt: W must be at least 1");
      end
   endgenerate

   assign wrap = adv && (cnt == limit);

   always_ff @(posedge clk) begin
      if (!rst_n || clr)
         cnt <= '0;
      else if (adv)
         cnt <= wrap ? '0 : cnt + 1'b1;
   end

   // R7: a running counter stays within its terminal value, so it always wraps.
   assert_in_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |-> (cnt <= limit));

   // R8: a clear leaves the counter at zero on the next edge.
   assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));

endmodule

// File: rtl/pacer_src_mux.sv
module pacer_src_mux
   import pacer_pkg::*;
(
   input  logic [1:0] sel,
   input  logic       base_tick,
   input  logic       decade_tick,
   input  logic       ext_tick,
   output logic       src_tick
);

   pacer_src_e src;

   always_comb begin
      src = decode_src(sel);
      unique case (src)
         SRC_BASE:   src_tick = base_tick;
         SRC_DECADE: src_tick = decade_tick;
         SRC_EXT:    src_tick = ext_tick;
         default:    src_tick = 1'b0;
      endcase
   end

endmodule

// File: rtl/interval_pacer.sv
module interval_pacer #(
   parameter int MW         = 16,
   parameter int NW         = 8,
   parameter int DECADE_DIV = 10,
   parameter bit DECADE_EN  = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cnt_en,
   input  logic          bit_tick,
   input  logic [MW-1:0] prescale_m,
   input  logic [1:0]    src_sel,
   input  logic [NW-1:0] interval_n,
   output logic          done_pulse
);

   localparam int DW = (DECADE_DIV > 1) ? $clog2(DECADE_DIV) : 1;
   localparam logic [DW-1:0] DEC_LIMIT = DW'(DECADE_DIV - 1);

   generate
      if (MW < 1 || NW < 1) begin : g_bad_widths
         initial $error("interval_pacer: MW and NW must be at least 1");
      end
      if (DECADE_EN && DECADE_DIV < 2) begin : g_bad_decade
         initial $error("interval_pacer: DECADE_DIV must be at least 2");
      end
   endgenerate

   // Configuration held while counting; refreshed on every edge with enable low.
   logic [MW-1:0] m_q;
   logic [NW-1:0] n_q;
   logic [1:0]    sel_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         m_q   <= '0;
         n_q   <= '0;
         sel_q <= '0;
      end else if (!cnt_en) begin
         m_q   <= prescale_m;
         n_q   <= interval_n;
         sel_q <= src_sel;
      end
   end

   // Prescaler: a divide value of zero is treated as one.
   logic [MW-1:0] m_limit;
   logic [MW-1:0] pre_cnt;
   logic          base_tick;

   assign m_limit = (m_q == '0) ? '0 : m_q - 1'b1;

   pacer_modcnt #(.W(MW)) u_prescale (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!cnt_en),
      .adv   (cnt_en),
      .limit (m_limit),
      .cnt   (pre_cnt),
      .wrap  (base_tick)
   );

   // Optional fixed decade stage after the prescaler.
   logic decade_tick;

   generate
      if (DECADE_EN) begin : g_decade
         logic [DW-1:0] dec_cnt;
         pacer_modcnt #(.W(DW)) u_decade (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (!cnt_en),
            .adv   (base_tick),
            .limit (DEC_LIMIT),
            .cnt   (dec_cnt),
            .wrap  (decade_tick)
         );
      end else begin : g_no_decade
         assign decade_tick = base_tick;
      end
   endgenerate

   // Source selection.
   logic ext_tick;
   logic src_tick;

   assign ext_tick = cnt_en && bit_tick;

   pacer_src_mux u_mux (
      .sel         (sel_q),
      .base_tick   (base_tick),
      .decade_tick (decade_tick),
      .ext_tick    (ext_tick),
      .src_tick    (src_tick)
   );

   // Interval counter.
   logic          n_zero;
   logic [NW-1:0] n_limit;
   logic [NW-1:0] int_cnt;
   logic          int_wrap;

   assign n_zero  = (n_q == '0);
   assign n_limit = n_zero ? '0 : n_q - 1'b1;

   pacer_modcnt #(.W(NW)) u_interval (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!cnt_en),
      .adv   (src_tick && !n_zero),
      .limit (n_limit),
      .cnt   (int_cnt),
      .wrap  (int_wrap)
   );

   assign done_pulse = cnt_en && (n_zero || int_wrap);

   // R4: in external mode with a nonzero interval, a pulse needs a bit tick.
   assert_ext_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_pulse && sel_q[0] && !n_zero) |-> bit_tick);

   // R2: in base mode a pulse coincides with a prescaler wrap.
   assert_base_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (done_pulse && sel_q == 2'b00 && !n_zero) |-> (pre_cnt == m_limit));

   // R8: after enable drops, the prescaler and interval counter are cleared.
   assert_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_en |=> (pre_cnt == '0 && int_cnt == '0));

   // R9: the held configuration does not move while counting.
   assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && $past(cnt_en)) |-> ($stable(m_q) && $stable(n_q) && $stable(sel_q)));

endmodule

// File: tb/interval_pacer_bench.sv
module interval_pacer_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_en = 1'b0;
   logic        bit_tick = 1'b0;
   logic [15:0] prescale_m = '0;
   logic [1:0]  src_sel = '0;
   logic [7:0]  interval_n = '0;
   logic        done_pulse;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   interval_pacer u_interval_pacer (
      .clk        (clk),
      .rst_n      (rst_n),
      .cnt_en     (cnt_en),
      .bit_tick   (bit_tick),
      .prescale_m (prescale_m),
      .src_sel    (src_sel),
      .interval_n (interval_n),
      .done_pulse (done_pulse)
   );

   task automatic check(input logic act, input logic exp, input string req, input int k);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s cycle %0d: done_pulse=%b expected %b", req, k, act, exp);
      end
   endtask

   // Load a configuration with enable low, then run enabled for a number of cycles.
   // tickp: bit_tick every tickp-th enabled cycle (0 = none). alter: scramble inputs mid-run.
   task automatic run_seg(input int m, input int n, input logic [1:0] sel,
                          input int cycles, input int tickp, input bit alter,
                          input string req);
      int meff;
      int period;
      int tcount;
      logic exp;
      @(negedge clk);
      cnt_en     = 1'b0;
      bit_tick   = 1'b0;
      prescale_m = 16'(m);
      interval_n = 8'(n);
      src_sel    = sel;
      meff   = (m == 0) ? 1 : m;
      period = meff * (sel[1] ? 10 : 1) * n;
      tcount = 0;
      for (int k = 1; k <= cycles; k++) begin
         @(negedge clk);
         cnt_en   = 1'b1;
         bit_tick = (tickp != 0) && (k % tickp == 0);
         if (alter && k == cycles / 2) begin
            prescale_m = 16'(m + 3);
            interval_n = 8'(n + 1);
            src_sel    = ~sel;
         end
         #1;
         if (n == 0)
            exp = 1'b1;
         else if (sel[0]) begin
            if (bit_tick) tcount++;
            exp = bit_tick && (tcount % n == 0);
         end else
            exp = (k % period == 0);
         check(done_pulse, exp, req, k);
      end
      @(negedge clk);
      cnt_en   = 1'b0;
      bit_tick = 1'b1;
      #1;
      check(done_pulse, 1'b0, "R8 R10 quiet while disabled", 0);
      @(negedge clk);
      bit_tick = 1'b0;
   endtask

   task automatic t_reset;
      #1;
      check(done_pulse, 1'b0, "R1 during reset", 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      check(done_pulse, 1'b0, "R1 after reset", 0);
   endtask

   task automatic t_base;
      run_seg(3, 4, 2'b00, 50, 0, 1'b0, "R2 base M3 N4");
      run_seg(1, 1, 2'b00, 8, 0, 1'b0, "R2 base M1 N1");
      run_seg(7, 2, 2'b00, 60, 0, 1'b0, "R7 base repeat M7 N2");
   endtask

   task automatic t_decade;
      run_seg(3, 4, 2'b10, 260, 0, 1'b0, "R3 decade M3 N4");
      run_seg(1, 2, 2'b10, 70, 0, 1'b0, "R3 decade M1 N2");
   endtask

   task automatic t_ext;
      run_seg(5, 3, 2'b01, 80, 4, 1'b0, "R4 ext sel01 N3");
      run_seg(5, 3, 2'b11, 80, 4, 1'b0, "R4 ext sel11 N3");
      run_seg(2, 1, 2'b01, 30, 3, 1'b0, "R4 ext N1");
   endtask

   task automatic t_zero_n;
      run_seg(4, 0, 2'b00, 6, 0, 1'b0, "R5 zero interval base");
      run_seg(4, 0, 2'b01, 6, 0, 1'b0, "R5 zero interval ext");
   endtask

   task automatic t_zero_m;
      run_seg(0, 5, 2'b00, 20, 0, 1'b0, "R6 zero prescale");
      run_seg(0, 1, 2'b10, 30, 0, 1'b0, "R6 zero prescale decade");
   endtask

   task automatic t_restart;
      // Stop mid-interval, then a fresh run must start from zero.
      run_seg(4, 5, 2'b00, 13, 0, 1'b0, "R8 partial run");
      run_seg(4, 5, 2'b00, 45, 0, 1'b0, "R8 restart from zero");
   endtask

   task automatic t_frozen;
      run_seg(3, 3, 2'b00, 40, 0, 1'b1, "R9 config change ignored");
      run_seg(2, 2, 2'b01, 40, 3, 1'b1, "R9 config change ignored ext");
   endtask

   task automatic t_tick_ignored;
      run_seg(2, 3, 2'b00, 30, 1, 1'b0, "R10 ticks ignored base");
      run_seg(1, 1, 2'b10, 25, 2, 1'b0, "R10 ticks ignored decade");
   endtask

   initial begin
      t_reset();
      t_base();
      t_decade();
      t_ext();
      t_zero_n();
      t_zero_m();
      t_restart();
      t_frozen();
      t_tick_ignored();
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule